// File: doc/BRIEF.md
# Runtime-Tap Pseudo-Random Bit Generator

This block is an 8-bit shift-register sequence generator with a single serial feedback path. A tap mask supplied on an input port picks which register stages feed the exclusive-OR that forms the new input bit. Each stage whose mask bit is 1 is included, and each stage whose mask bit is 0 contributes nothing. Changing the mask therefore changes the feedback polynomial without rebuilding the logic. The design detects a register that holds all zeros and shifts in a 1 in that case, so the sequence can never stall in the zero state.

The surrounding logic supplies a one-cycle advance strobe at whatever rate the application needs. Any baud-rate division or serial framing happens outside this block. A synchronous reset loads a seed from an input port, and the seed may be zero. The full register contents and the last stage are both available as outputs.

Top module: `tapmask_lfsr`

## Requirements
- R1: While `rst` is high at a rising clock edge, `state` takes the value of `seed` after that edge. A zero seed is loaded unchanged.
- R2: At an edge where `rst` is low and `step` is low, `state` keeps its value.
- R3: At an edge where `rst` is low and `step` is high, every stage k from 1 to 7 takes the previous value of stage k-1.
- R4: On a step from a non-zero state, stage 0 takes the XOR of all stages whose bit in `taps` is 1. Bit k of `taps` selects stage k.
- R5: A stage whose `taps` bit is 0 has no effect on the new stage-0 value.
- R6: On a step from the all-zero state, `state` becomes 8'h01 whatever `taps` holds.
- R7: `bit_out` always equals stage 7 of `state`.
- R8: With `taps` = 8'hB8 and a non-zero seed, the state returns to the seed after exactly 255 steps, and not earlier. All 255 non-zero values appear once.
- R9: With `taps` = 8'h00 and a non-zero seed, zeros are shifted in until the register is all zero. The next step then gives 8'h01, so the zero state recurs every 9 steps once it has been reached.
- R10: When `rst` and `step` are both high, the seed load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, loads `seed` |
| seed | input | 8 | Value loaded on reset |
| step | input | 1 | Advance strobe; the register shifts once per high cycle |
| taps | input | 8 | Feedback stage selection, bit k selects stage k |
| state | output | 8 | Register contents |
| bit_out | output | 1 | Last stage (stage 7) |

## Verification
Every stage of the register is visible on `state`, so a wrong feedback bit appears at stage 0 in the cycle after the faulty step. It then travels one stage per step and reaches `bit_out` seven steps later. A missed or duplicated zero escape shows up as a stuck all-zero `state` or a wrong 8'h01 transition in the cycle after the step. A wrong tap selection does not always change the next bit, but it breaks the 255-step period under mask 8'hB8 and so cannot hide for long.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
  localparam int unsigned LFSR_W_DEFAULT = 8;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_SHIFT = 2'd2
  } lfsr_act_e;
endpackage

// File: rtl/lfsr_step_ctrl.sv
module lfsr_step_ctrl
  import lfsr_pkg::*;
(
  input  logic      rst,
  input  logic      step,
  output lfsr_act_e act
);
  // reset load has priority over an advance
  always_comb begin
    if (rst)       act = ACT_LOAD;
    else if (step) act = ACT_SHIFT;
    else           act = ACT_HOLD;
  end
endmodule

// File: rtl/lfsr_feedback.sv
module lfsr_feedback #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] taps,
  output logic         fb
);
  logic [W-1:0] gated;
  logic [W:0]   chain;

  assign chain[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_tap
      assign gated[i]   = cur[i] & taps[i];
      assign chain[i+1] = chain[i] ^ gated[i];
    end
  endgenerate

  assign fb = chain[W];
endmodule

// File: rtl/lfsr_zero_detect.sv
module lfsr_zero_detect #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] cur,
  output logic         is_zero
);
  logic [W:0] any;

  assign any[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_or
      assign any[i+1] = any[i] | cur[i];
    end
  endgenerate

  assign is_zero = ~any[W];
endmodule

// File: rtl/lfsr_stage_reg.sv
module lfsr_stage_reg
  import lfsr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  lfsr_act_e    act,
  input  logic [W-1:0] load_val,
  input  logic         in_bit,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    case (act)
      ACT_LOAD:  q <= load_val;
      ACT_SHIFT: q <= {q[W-2:0], in_bit};
      default:   q <= q;
    endcase
  end
endmodule

// File: rtl/tapmask_lfsr.sv
module tapmask_lfsr
  import lfsr_pkg::*;
#(
  parameter int unsigned W = LFSR_W_DEFAULT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] seed,
  input  logic         step,
  input  logic [W-1:0] taps,
  output logic [W-1:0] state,
  output logic         bit_out
);
  localparam int unsigned MSB = W - 1;

  lfsr_act_e    act;
  logic         fb_xor;
  logic         zero_now;
  logic         in_bit;
  logic [W-1:0] q;

  lfsr_step_ctrl u_ctrl (
    .rst  (rst),
    .step (step),
    .act  (act)
  );

  lfsr_feedback #(.W(W)) u_fb (
    .cur  (q),
    .taps (taps),
    .fb   (fb_xor)
  );

  lfsr_zero_detect #(.W(W)) u_zd (
    .cur     (q),
    .is_zero (zero_now)
  );

  // lockup escape: an all-zero register always takes in a one
  assign in_bit = zero_now ? 1'b1 : fb_xor;

  lfsr_stage_reg #(.W(W)) u_reg (
    .clk      (clk),
    .act      (act),
    .load_val (seed),
    .in_bit   (in_bit),
    .q        (q)
  );

  assign state   = q;
  assign bit_out = q[MSB];
endmodule

// File: rtl/tapmask_lfsr_checker.sv
module tapmask_lfsr_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] seed,
  input logic         step,
  input logic [W-1:0] taps,
  input logic [W-1:0] state,
  input logic         bit_out
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  // R1, R10: reset loads the seed, even if step is high
  a_r1_seed_load: assert property (@(posedge clk)
    rst |=> state == $past(seed));

  // R2
  a_r2_hold: assert property (@(posedge clk) disable iff (rst || !armed)
    !step |=> $stable(state));

  // R3
  a_r3_shift: assert property (@(posedge clk) disable iff (rst || !armed)
    step |=> state[W-1:1] == $past(state[W-2:0]));

  // R4
  a_r4_feedback: assert property (@(posedge clk) disable iff (rst || !armed)
    (step && state != '0) |=> state[0] == $past(^(state & taps)));

  // R6
  a_r6_zero_escape: assert property (@(posedge clk) disable iff (rst || !armed)
    (step && state == '0) |=> state == {{(W-1){1'b0}}, 1'b1});

  // R7
  a_r7_out_tap: assert property (@(posedge clk) disable iff (!armed)
    bit_out == state[W-1]);
endmodule

bind tapmask_lfsr tapmask_lfsr_checker #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .seed    (seed),
  .step    (step),
  .taps    (taps),
  .state   (state),
  .bit_out (bit_out)
);

// File: tb/tapmask_lfsr_test.sv
`timescale 1ns/1ps
module tapmask_lfsr_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] seed = 8'h00;
  logic       step = 1'b0;
  logic [7:0] taps = 8'h00;
  logic [7:0] state;
  logic       bit_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tapmask_lfsr uut (
    .clk(clk), .rst(rst), .seed(seed), .step(step),
    .taps(taps), .state(state), .bit_out(bit_out)
  );

  function automatic logic [7:0] model_next(logic [7:0] s, logic [7:0] m);
    logic b;
    if (s == 8'h00) return 8'h01;
    b = ^(s & m);
    return {s[6:0], b};
  endfunction

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at the falling edge, sample 1 ns after the rising edge
  task automatic cyc(logic r, logic s);
    @(negedge clk);
    rst = r;
    step = s;
    @(posedge clk);
    #1;
  endtask

  task automatic load(logic [7:0] v);
    seed = v;
    cyc(1'b1, 1'b0);
  endtask

  task automatic t_reset();
    load(8'h5A);
    check8("R1", state, 8'h5A);
    check8("R7", {7'd0, bit_out}, 8'h00);
    load(8'h00);
    check8("R1", state, 8'h00);
  endtask

  task automatic t_hold();
    load(8'hC3);
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0);
    check8("R2", state, 8'hC3);
  endtask

  task automatic t_shift_fb(logic [7:0] s0, logic [7:0] m, int n);
    logic [7:0] exp;
    taps = m;
    load(s0);
    exp = s0;
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, 1'b1);
      exp = model_next(exp, m);
      check8("R3/R4", state, exp);
      check8("R7", {7'd0, bit_out}, {7'd0, exp[7]});
    end
  endtask

  task automatic t_exclude();
    // R5: stages 1 and 6 are set but masked off; only stage 0 is tapped
    taps = 8'h01;
    load(8'h42);
    cyc(1'b0, 1'b1);
    check8("R5", state, 8'h84);
    load(8'h43);
    cyc(1'b0, 1'b1);
    check8("R5", state, 8'h87);
  endtask

  task automatic t_zero_escape();
    taps = 8'hFF;
    load(8'h00);
    cyc(1'b0, 1'b1);
    check8("R6", state, 8'h01);
  endtask

  task automatic t_max_period();
    logic [255:0] seen;
    int first_ret;
    seen = '0;
    first_ret = -1;
    taps = 8'hB8;
    load(8'h01);
    seen[8'h01] = 1'b1;
    for (int i = 1; i <= 255; i++) begin
      cyc(1'b0, 1'b1);
      if (state == 8'h01 && first_ret < 0) first_ret = i;
      seen[state] = 1'b1;
    end
    check8("R8 period", first_ret[7:0], 8'hFF);
    total++;
    if (first_ret != 255) begin
      bad++;
      $display("FAIL R8 actual=%0d expected=255", first_ret);
    end
    check8("R8 coverage", 8'($countones(seen[255:1])), 8'hFF);
  endtask

  task automatic t_zero_mask();
    logic [7:0] exp;
    taps = 8'h00;
    load(8'h81);
    exp = 8'h02;
    for (int i = 0; i < 7; i++) begin
      cyc(1'b0, 1'b1);
      check8("R9 drain", state, exp);
      exp = exp << 1;
    end
    cyc(1'b0, 1'b1);
    check8("R9 zero", state, 8'h00);
    cyc(1'b0, 1'b1);
    check8("R9 escape", state, 8'h01);
    for (int i = 0; i < 8; i++) cyc(1'b0, 1'b1);
    check8("R9 recur", state, 8'h00);
  endtask

  task automatic t_priority();
    taps = 8'hB8;
    load(8'h10);
    seed = 8'hE7;
    cyc(1'b1, 1'b1);
    check8("R10", state, 8'hE7);
  endtask

  initial begin
    cyc(1'b1, 1'b0);
    t_reset();
    t_hold();
    t_shift_fb(8'h01, 8'hB8, 12);
    t_shift_fb(8'hA5, 8'h81, 10);
    t_shift_fb(8'h3C, 8'h6E, 10);
    t_exclude();
    t_zero_escape();
    t_max_period();
    t_zero_mask();
    t_priority();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule